// File: doc/BRIEF.md
# Strap-Addressed Two-Wire Bus Target

This block is the bit-level front end of a target device on a two-wire serial bus (SMBus or I2C style). A fast system clock oversamples the clock and data lines. The block finds start and stop conditions and shifts in the address byte and any write bytes. It answers with an acknowledge by pulling the data line low. During reads it shifts bytes out, taking each one from a parallel port. It drives the data line only through an open-drain pull-low enable.

The target address comes from two strap inputs. With the enable strap high, the fixed address 0x2E applies. With it low, the select strap picks 0x2C (low) or 0x2D (high). Leaving reset, the block follows the straps. At the rising clock edge that begins the eighth bit of the first address byte that matches, the address is frozen for good, so later strap changes do nothing. Behind the block, the register logic sees one-cycle write strobes carrying the received byte. It also sees one-cycle read requests, to which it answers with the next byte to send.

Top module: `smb_strap_target`

## Requirements
- R1: The target address is 0x2E when `strap_en_i` is 1 (whatever `strap_sel_i` is), 0x2C when `strap_en_i` is 0 and `strap_sel_i` is 0, and 0x2D when `strap_en_i` is 0 and `strap_sel_i` is 1; the address byte is 7 address bits MSB first followed by a direction bit (0 = write, 1 = read).
- R2: After an address byte that does not match, the block never asserts `sda_pull_o` and raises no strobe until the next start condition.
- R3: Until the first matching address byte, the address follows the straps; from the rising clock edge of that byte's eighth bit onward, the address is frozen and strap changes have no effect until reset.
- R4: A start (data falling while clock is high) at any point, including in the middle of a byte, restarts address reception and releases the data line.
- R5: After a matching address byte and after every write byte, the block pulls the data line low for the whole ninth clock (acknowledge).
- R6: Each write byte is received MSB first and presented on `wr_data_o` with a one-cycle `wr_valid_o` pulse, raised after the eighth rising clock edge of that byte; any number of bytes may follow one address.
- R7: During a read, `rd_req_o` pulses once in the ninth clock before each byte to be sent; the byte on `rd_data_i` is then shifted out MSB first, with `sda_pull_o` high exactly for the 0 bits.
- R8: When the master does not acknowledge a read byte (data high on the ninth clock), the block stops driving and requests no more bytes until the next start.
- R9: A stop (data rising while clock is high) returns the block to idle with the data line released.
- R10: `sda_pull_o` changes only while the clock line is low.
- R11: In reset and just after it, `sda_pull_o`, `wr_valid_o` and `rd_req_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| strap_en_i | input | 1 | Strap: 1 selects the fixed address |
| strap_sel_i | input | 1 | Strap: picks between the two alternate addresses |
| rd_data_i | input | 8 | Byte to send, valid from the cycle after `rd_req_o` |
| sda_pull_o | output | 1 | 1 pulls the data line low; 0 releases it |
| wr_valid_o | output | 1 | One-cycle strobe for a received write byte |
| wr_data_o | output | 8 | Received write byte |
| rd_req_o | output | 1 | One-cycle request for the next read byte |

## Verification
The bench builds the block with its default parameters: a two-flop synchroniser and the three standard strap addresses. With these, it can probe every strap combination against the address the bench itself expects. It can also unlock the address again through reset, and it can check the freeze by moving the straps to an address that would otherwise match. A bus half period of 16 system clocks leaves the synchroniser delay well inside each clock phase. This lets the bench test the edges of the protocol directly: a repeated start in the middle of a byte, a master not-acknowledge at the end of a read, and idle clocking after it.

// File: rtl/smbt_pkg.sv
package smbt_pkg;

  localparam int BYTE_W = 8;
  localparam int ADR_W  = BYTE_W - 1;
  localparam int CNT_W  = $clog2(BYTE_W + 2);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_BYTE = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W + 1);

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_ADR_ACK,
    PH_WR_BYTE,
    PH_WR_ACK,
    PH_RD_BYTE,
    PH_RD_ACK
  } phase_t;

  // Strap decode: the enable strap wins, otherwise select chooses.
  function automatic logic [ADR_W-1:0] pick_addr(
    input logic             en,
    input logic             sel,
    input logic [ADR_W-1:0] a_fix,
    input logic [ADR_W-1:0] a_lo,
    input logic [ADR_W-1:0] a_hi
  );
    return en ? a_fix : (sel ? a_hi : a_lo);
  endfunction

  function automatic logic addr_hit(
    input logic [ADR_W-1:0] got,
    input logic [ADR_W-1:0] want
  );
    return got == want;
  endfunction

endpackage

// File: rtl/smbt_sync.sv
module smbt_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] prev_o
);

  for (genvar g = 0; g < W; g++) begin : g_line
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe      <= '1;
        prev_o[g] <= 1'b1;
      end else begin
        pipe      <= {pipe[STAGES-2:0], raw_i[g]};
        prev_o[g] <= pipe[STAGES-1];
      end
    end

    assign lvl_o[g] = pipe[STAGES-1];
  end

endmodule

// File: rtl/smbt_events.sv
module smbt_events (
  input  logic scl,
  input  logic sda,
  input  logic scl_d,
  input  logic sda_d,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic scl_held_high;

  assign scl_held_high = scl & scl_d;
  assign scl_rise      = scl & ~scl_d;
  assign scl_fall      = ~scl & scl_d;
  assign start_evt     = scl_held_high & sda_d & ~sda;
  assign stop_evt      = scl_held_high & ~sda_d & sda;

endmodule

// File: rtl/smbt_addr_lock.sv
module smbt_addr_lock
  import smbt_pkg::*;
#(
  parameter logic [ADR_W-1:0] A_FIX = 7'h2E,
  parameter logic [ADR_W-1:0] A_LO  = 7'h2C,
  parameter logic [ADR_W-1:0] A_HI  = 7'h2D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_en,
  input  logic             strap_sel,
  input  logic             lock_req,
  output logic [ADR_W-1:0] cur_addr,
  output logic             locked
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= A_FIX;
      locked   <= 1'b0;
    end else begin
      if (lock_req) begin
        locked <= 1'b1;
      end
      if (!locked && !lock_req) begin
        cur_addr <= pick_addr(strap_en, strap_sel, A_FIX, A_LO, A_HI);
      end
    end
  end

endmodule

// File: rtl/smbt_engine.sv
module smbt_engine
  import smbt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [ADR_W-1:0]  cur_addr,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              addr_match_o,
  output logic              sda_pull_o,
  output logic              wr_valid_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_req_o
);

  phase_t            ph;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-2:0] rx;
  logic [BYTE_W-1:0] tx;
  logic              dir_rd;
  logic              hit;
  logic              mst_ack;
  logic              last_rise;
  logic              fall_byte;
  logic              fall_ack;

  assign last_rise    = scl_rise && (cnt == CNT_LAST);
  assign fall_byte    = scl_fall && (cnt == CNT_BYTE);
  assign fall_ack     = scl_fall && (cnt == CNT_ACK);
  assign addr_match_o = (ph == PH_ADDR) && last_rise && addr_hit(rx, cur_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph         <= PH_IDLE;
      cnt        <= '0;
      rx         <= '0;
      tx         <= '0;
      dir_rd     <= 1'b0;
      hit        <= 1'b0;
      mst_ack    <= 1'b0;
      sda_pull_o <= 1'b0;
      wr_valid_o <= 1'b0;
      wr_data_o  <= '0;
      rd_req_o   <= 1'b0;
    end else begin
      wr_valid_o <= 1'b0;
      rd_req_o   <= 1'b0;
      if (start_evt) begin
        ph         <= PH_ADDR;
        cnt        <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_evt) begin
        ph         <= PH_IDLE;
        sda_pull_o <= 1'b0;
      end else begin
        case (ph)
          PH_ADDR: begin
            if (scl_rise) begin
              rx  <= {rx[BYTE_W-3:0], sda_lvl};
              cnt <= cnt + CNT_W'(1);
              if (last_rise) begin
                hit    <= addr_match_o;
                dir_rd <= sda_lvl;
              end
            end else if (fall_byte) begin
              if (hit) begin
                sda_pull_o <= 1'b1;
                ph         <= PH_ADR_ACK;
              end else begin
                ph <= PH_IDLE;
              end
            end
          end
          PH_ADR_ACK: begin
            if (scl_rise) begin
              cnt      <= CNT_ACK;
              rd_req_o <= dir_rd;
            end else if (fall_ack) begin
              cnt <= '0;
              if (dir_rd) begin
                tx         <= rd_data_i;
                sda_pull_o <= ~rd_data_i[BYTE_W-1];
                ph         <= PH_RD_BYTE;
              end else begin
                sda_pull_o <= 1'b0;
                ph         <= PH_WR_BYTE;
              end
            end
          end
          PH_WR_BYTE: begin
            if (scl_rise) begin
              rx  <= {rx[BYTE_W-3:0], sda_lvl};
              cnt <= cnt + CNT_W'(1);
              if (last_rise) begin
                wr_valid_o <= 1'b1;
                wr_data_o  <= {rx, sda_lvl};
              end
            end else if (fall_byte) begin
              sda_pull_o <= 1'b1;
              ph         <= PH_WR_ACK;
            end
          end
          PH_WR_ACK: begin
            if (scl_rise) begin
              cnt <= CNT_ACK;
            end else if (fall_ack) begin
              sda_pull_o <= 1'b0;
              cnt        <= '0;
              ph         <= PH_WR_BYTE;
            end
          end
          PH_RD_BYTE: begin
            if (scl_rise) begin
              cnt <= cnt + CNT_W'(1);
            end else if (fall_byte) begin
              sda_pull_o <= 1'b0;
              ph         <= PH_RD_ACK;
            end else if (scl_fall && cnt != '0) begin
              tx         <= tx << 1;
              sda_pull_o <= ~tx[BYTE_W-2];
            end
          end
          PH_RD_ACK: begin
            if (scl_rise) begin
              cnt      <= CNT_ACK;
              mst_ack  <= ~sda_lvl;
              rd_req_o <= ~sda_lvl;
            end else if (fall_ack) begin
              if (mst_ack) begin
                tx         <= rd_data_i;
                sda_pull_o <= ~rd_data_i[BYTE_W-1];
                cnt        <= '0;
                ph         <= PH_RD_BYTE;
              end else begin
                sda_pull_o <= 1'b0;
                ph         <= PH_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/smb_strap_target.sv
module smb_strap_target
  import smbt_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [ADR_W-1:0] ADDR_FIXED  = 7'h2E,
  parameter logic [ADR_W-1:0] ADDR_SEL_LO = 7'h2C,
  parameter logic [ADR_W-1:0] ADDR_SEL_HI = 7'h2D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              strap_en_i,
  input  logic              strap_sel_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_pull_o,
  output logic              wr_valid_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_req_o
);

  logic [1:0]       lvl;
  logic [1:0]       prev;
  logic             scl_lvl;
  logic             sda_lvl;
  logic             scl_rise;
  logic             scl_fall;
  logic             start_evt;
  logic             stop_evt;
  logic             lock_evt;
  logic             addr_locked;
  logic [ADR_W-1:0] cur_addr;

  smbt_sync #(.W(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  ({sda_i, scl_i}),
    .lvl_o  (lvl),
    .prev_o (prev)
  );

  assign scl_lvl = lvl[0];
  assign sda_lvl = lvl[1];

  smbt_events i_events (
    .scl       (scl_lvl),
    .sda       (sda_lvl),
    .scl_d     (prev[0]),
    .sda_d     (prev[1]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  smbt_addr_lock #(
    .A_FIX (ADDR_FIXED),
    .A_LO  (ADDR_SEL_LO),
    .A_HI  (ADDR_SEL_HI)
  ) i_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_en  (strap_en_i),
    .strap_sel (strap_sel_i),
    .lock_req  (lock_evt),
    .cur_addr  (cur_addr),
    .locked    (addr_locked)
  );

  smbt_engine i_engine (
    .clk          (clk),
    .rst_n        (rst_n),
    .sda_lvl      (sda_lvl),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .start_evt    (start_evt),
    .stop_evt     (stop_evt),
    .cur_addr     (cur_addr),
    .rd_data_i    (rd_data_i),
    .addr_match_o (lock_evt),
    .sda_pull_o   (sda_pull_o),
    .wr_valid_o   (wr_valid_o),
    .wr_data_o    (wr_data_o),
    .rd_req_o     (rd_req_o)
  );

endmodule

// File: rtl/smbt_checker.sv
module smbt_checker
  import smbt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             scl_lvl,
  input logic             scl_rise,
  input logic             start_evt,
  input logic             stop_evt,
  input logic             addr_locked,
  input logic [ADR_W-1:0] cur_addr,
  input logic             sda_pull,
  input logic             wr_valid,
  input logic             rd_req
);

  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_lvl); // R10

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    addr_locked |=> (addr_locked && $stable(cur_addr))); // R3

  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid); // R6

  AST_WR_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(scl_rise)); // R6

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req); // R7

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_pull); // R9

  AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_pull); // R4

endmodule

bind smb_strap_target smbt_checker i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scl_lvl     (scl_lvl),
  .scl_rise    (scl_rise),
  .start_evt   (start_evt),
  .stop_evt    (stop_evt),
  .addr_locked (addr_locked),
  .cur_addr    (cur_addr),
  .sda_pull    (sda_pull_o),
  .wr_valid    (wr_valid_o),
  .rd_req      (rd_req_o)
);

// File: tb/test_smb_strap_target.sv
module test_smb_strap_target;

  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       en = 1'b1;
  logic       sel = 1'b0;
  logic [7:0] rd_data = 8'h00;
  logic       pull;
  logic       wr_valid;
  logic [7:0] wr_data;
  logic       rd_req;
  wire        sda_bus = m_sda & ~pull;

  int checks = 0;
  int errors = 0;
  int wr_n = 0;
  int rd_n = 0;
  int r10_bad = 0;
  bit done = 1'b0;
  logic [7:0] wr_log [64];
  logic [7:0] rd_plan [8];
  logic prev_pull = 1'b0;

  always #10 clk = ~clk;

  smb_strap_target i_smb_strap_target (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (m_scl),
    .sda_i       (sda_bus),
    .strap_en_i  (en),
    .strap_sel_i (sel),
    .rd_data_i   (rd_data),
    .sda_pull_o  (pull),
    .wr_valid_o  (wr_valid),
    .wr_data_o   (wr_data),
    .rd_req_o    (rd_req)
  );

  // Bus-side register model: log write strobes, answer read requests.
  always @(negedge clk) begin
    if (wr_valid) begin
      wr_log[wr_n % 64] = wr_data;
      wr_n++;
    end
    if (rd_req) begin
      rd_data = rd_plan[rd_n % 8];
      rd_n++;
    end
    if (pull !== prev_pull && m_scl === 1'b1) r10_bad++; // R10
    prev_pull = pull;
  end

  function automatic logic [6:0] exp_addr(input logic e, input logic s);
    case ({e, s})
      2'b00:   return 7'h2C;
      2'b01:   return 7'h2D;
      default: return 7'h2E;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    m_scl = 1'b1;
    m_sda = 1'b1;
    rst_n = 1'b0;
    wt(4);
    rst_n = 1'b1;
    wt(4);
  endtask

  task automatic send_start();
    m_sda = 1'b1; wt(Q);
    m_scl = 1'b1; wt(Q);
    m_sda = 1'b0; wt(Q);
    m_scl = 1'b0; wt(Q);
  endtask

  task automatic send_stop();
    m_sda = 1'b0; wt(Q);
    m_scl = 1'b1; wt(Q);
    m_sda = 1'b1; wt(Q);
  endtask

  task automatic clock_bit(input bit b, output bit seen);
    m_sda = b;    wt(Q);
    m_scl = 1'b1; wt(Q);
    seen = sda_bus;
    wt(Q);
    m_scl = 1'b0; wt(Q);
  endtask

  task automatic put_byte(input logic [7:0] v, output bit acked, output bit odd);
    bit s;
    odd = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(v[i], s);
      if (s != v[i]) odd = 1'b1;
    end
    clock_bit(1'b1, s);
    acked = !s;
  endtask

  task automatic get_byte(input bit give_ack, output logic [7:0] v);
    bit s;
    v = 8'h00;
    for (int i = 0; i < 8; i++) begin
      clock_bit(1'b1, s);
      v = {v[6:0], s};
    end
    clock_bit(!give_ack, s);
  endtask

  initial begin
    bit         ack;
    bit         odd;
    logic [6:0] adr;
    logic [7:0] v;
    int         base;
    void'($urandom(32'h5EED));
    rd_plan[0] = 8'hA5; rd_plan[1] = 8'h3C; rd_plan[2] = 8'h81; rd_plan[3] = 8'h7E;
    rd_plan[4] = 8'h00; rd_plan[5] = 8'hFF; rd_plan[6] = 8'h12; rd_plan[7] = 8'h34;

    // R11: reset state
    wt(3);
    chk(pull == 1'b0 && wr_valid == 1'b0 && rd_req == 1'b0, "R11 in reset", {pull, wr_valid, rd_req}, 0);
    rst_n = 1'b1;
    wt(2);
    chk(pull == 1'b0 && wr_valid == 1'b0 && rd_req == 1'b0, "R11 after reset", {pull, wr_valid, rd_req}, 0);

    // R1: each strap combination answers its own address
    for (int c = 0; c < 4; c++) begin
      en = c[1]; sel = c[0];
      do_reset();
      send_start();
      put_byte({exp_addr(en, sel), 1'b0}, ack, odd);
      chk(ack, "R1 strap decode ack", ack, 1);
      send_stop();
    end

    // R2: mismatch stays silent
    en = 1'b1; sel = 1'b0;
    do_reset();
    base = wr_n;
    send_start();
    put_byte({7'h2C, 1'b0}, ack, odd);
    chk(!ack, "R2 wrong address not acked", ack, 0);
    put_byte(8'h00, ack, odd);
    chk(!ack && !odd && wr_n == base, "R2 silent after mismatch", wr_n - base, 0);
    send_stop();

    // Random rounds: straps moved after reset, then a write transfer
    for (int r = 0; r < 10; r++) begin
      int k;
      en = 1'($urandom); sel = 1'($urandom);
      do_reset();
      en = 1'($urandom); sel = 1'($urandom);
      wt(4);
      k = int'($urandom % 4);
      adr = (k == 0) ? 7'h2C : (k == 1) ? 7'h2D : (k == 2) ? 7'h2E : 7'($urandom);
      send_start();
      put_byte({adr, 1'b0}, ack, odd);
      chk(ack == (adr == exp_addr(en, sel)), "R1 R3 address follows straps", ack, adr == exp_addr(en, sel));
      if (ack) begin
        int n;
        n = 1 + int'($urandom % 3);
        for (int j = 0; j < n; j++) begin
          v = 8'($urandom);
          base = wr_n;
          put_byte(v, ack, odd);
          chk(ack, "R5 write byte acked", ack, 1);
          chk(wr_n == base + 1 && wr_log[base % 64] == v, "R6 write strobe data", wr_log[base % 64], v);
        end
        send_stop();
        chk(pull == 1'b0, "R9 released after stop", pull, 0);
        // R3: lock holds against strap change
        en = 1'b0; sel = (adr == 7'h2C);
        wt(4);
        send_start();
        put_byte({exp_addr(en, sel), 1'b0}, ack, odd);
        chk(!ack, "R3 new strap address ignored after lock", ack, 0);
        send_stop();
        send_start();
        put_byte({adr, 1'b0}, ack, odd);
        chk(ack, "R3 locked address still answers", ack, 1);
        send_stop();
      end else begin
        base = wr_n;
        put_byte(8'($urandom), ack, odd);
        chk(!ack && !odd && wr_n == base, "R2 silent after mismatch", wr_n - base, 0);
        send_stop();
      end
    end

    // R7 / R8: read three bytes, last one not acknowledged
    en = 1'b1; sel = 1'b1;
    do_reset();
    rd_n = 0;
    send_start();
    put_byte({7'h2E, 1'b1}, ack, odd);
    chk(ack, "R5 read address acked", ack, 1);
    get_byte(1'b1, v);
    chk(v == 8'hA5, "R7 read byte 0", v, 8'hA5);
    get_byte(1'b1, v);
    chk(v == 8'h3C, "R7 read byte 1", v, 8'h3C);
    get_byte(1'b0, v);
    chk(v == 8'h81, "R7 read byte 2", v, 8'h81);
    chk(rd_n == 3, "R7 one request per byte", rd_n, 3);
    put_byte(8'hFF, ack, odd);
    chk(!ack && !odd && rd_n == 3, "R8 idle after master nack", rd_n, 3);
    send_stop();

    // R4: repeated start in mid byte, then repeated start into a read
    send_start();
    put_byte({7'h2E, 1'b0}, ack, odd);
    for (int i = 0; i < 4; i++) begin
      bit s;
      clock_bit(1'b1, s);
    end
    send_start();
    base = wr_n;
    put_byte({7'h2E, 1'b0}, ack, odd);
    chk(ack, "R4 address after repeated start", ack, 1);
    put_byte(8'h5A, ack, odd);
    chk(wr_n == base + 1 && wr_log[base % 64] == 8'h5A, "R4 R6 byte after repeated start", wr_log[base % 64], 8'h5A);
    send_start();
    put_byte({7'h2E, 1'b1}, ack, odd);
    get_byte(1'b0, v);
    chk(v == 8'h7E, "R4 R7 read after repeated start", v, 8'h7E);
    send_stop();
    chk(pull == 1'b0, "R9 released after stop", pull, 0);

    chk(r10_bad == 0, "R10 pull changed while clock high", r10_bad, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
      $finish;
    end
  end

endmodule